// File: doc/BRIEF.md
# I/O Page-Table Entry Fetcher

This block takes an I/O virtual address on a request/response handshake and finds the one 32-bit page-table entry that covers it. It first strips the bits of the translation window's start address from the incoming address. It then turns the remaining page number into a word-aligned byte offset and adds that offset to a table base. The table base is a programmed register value scaled up by sixteen. The block reads the entry from memory with a single-beat read and returns it as the page flags of the lookup.

Two configuration registers are written through a small write-only port: the table base and the window-start mask. Only one lookup is in flight at a time. The entry address is captured when the request is accepted, so writes to the configuration registers during a lookup only affect the next one. The memory data bus is little-endian, while table entries are stored big-endian, so the fetched word is byte-reversed before it is returned.

Top module: `iopte_fetch`

## Requirements
- R1: After reset both configuration registers hold zero, `req_ready` is 1, and `mem_valid` and `rsp_valid` are 0.
- R2: The memory read address is `(base << 4) + (((vaddr & ~window) >> (PAGE_SHIFT-2)) & ~3)`, taken modulo 2^ADDR_W, with `PAGE_SHIFT` defaulting to 12. Every entry is therefore 4 bytes long and each page has one entry.
- R3: A write with `cfg_sel` = 0 loads the table base. A write with `cfg_sel` = 1 loads the window-start mask. The new value is used by requests accepted from the next cycle onward.
- R4: While `mem_valid` is high and `mem_ready` is low, `mem_valid` stays high and `mem_addr` does not change.
- R5: `rsp_flags` is the word returned on `rd_data`, with its bytes reversed: bits [7:0] of `rd_data` appear in bits [31:24] of `rsp_flags`, bits [15:8] in [23:16], bits [23:16] in [15:8], and bits [31:24] in [7:0]. It is shown in the cycle after `rd_valid`.
- R6: Only one lookup is outstanding. `req_ready` falls in the cycle after a request is accepted and rises again only after the response handshake. `rsp_valid` and `rsp_flags` are held until `rsp_ready`.
- R7: A configuration write made while a lookup is in flight does not change that lookup's memory address.
- R8: `rd_valid` has no effect unless a read is awaiting data: a pulse before the read address is accepted neither produces a response nor changes the flags that are later returned.
- R9: `mem_valid` and `rsp_valid` are never high together, and `req_ready` is low whenever either of them is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Register select: 0 table base, 1 window-start mask |
| cfg_wdata | input | ADDR_W | Configuration write data |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Block can accept a lookup |
| req_vaddr | input | ADDR_W | I/O virtual address to look up |
| rsp_valid | output | 1 | Page flags are valid |
| rsp_ready | input | 1 | Requester takes the flags |
| rsp_flags | output | 32 | Fetched entry, in host byte order |
| mem_valid | output | 1 | Read address valid |
| mem_ready | input | 1 | Memory accepts the read address |
| mem_addr | output | ADDR_W | Byte address of the entry |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 32 | Read data, little-endian lanes |

## Verification
The hardest case to reach is a configuration write that lands after a request has been accepted but before the memory read address has been taken. The bench makes this happen by holding `mem_ready` low for a few cycles after acceptance and writing new base and window values during that gap. It then checks that the held address still matches the old configuration, and that the following lookup uses the new one. A stray `rd_valid` pulse is driven while the read address is still stalled, to show that it is ignored. The address arithmetic is swept over many base, window and address patterns, and the sweep includes overflow of the sum and an all-ones window.

// File: rtl/iopte_pkg.sv
package iopte_pkg;

    localparam int unsigned ENTRY_BYTES = 4;
    localparam int unsigned BASE_SCALE  = 4;
    localparam int unsigned WORD_W      = 8 * ENTRY_BYTES;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RESP  = 2'd3
    } fetch_state_e;

    typedef enum logic {
        SEL_BASE   = 1'b0,
        SEL_WINDOW = 1'b1
    } cfg_sel_e;

    function automatic word_t reverse_bytes(word_t w);
        word_t r;
        for (int b = 0; b < ENTRY_BYTES; b++) begin
            r[8*b +: 8] = w[8*(ENTRY_BYTES-1-b) +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/iopte_cfg_regs.sv
module iopte_cfg_regs
    import iopte_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] base_o,
    output logic [ADDR_W-1:0] window_o
);

    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] window_q;
    cfg_sel_e          sel;

    assign sel = cfg_sel_e'(cfg_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q   <= '0;
            window_q <= '0;
        end else if (cfg_we) begin
            if (sel == SEL_BASE) begin
                base_q <= cfg_wdata;
            end else begin
                window_q <= cfg_wdata;
            end
        end
    end

    assign base_o   = base_q;
    assign window_o = window_q;

    p_cfg_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> ($stable(base_o) && $stable(window_o)));

    p_cfg_base_r3: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !cfg_sel) |=> (base_o == $past(cfg_wdata)) && $stable(window_o));

endmodule

// File: rtl/iopte_idx_calc.sv
module iopte_idx_calc
    import iopte_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned PAGE_SHIFT = 12
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] window_i,
    input  logic [ADDR_W-1:0] vaddr_i,
    output logic [ADDR_W-1:0] pte_addr_o
);

    localparam int unsigned IDX_SHIFT = PAGE_SHIFT - 2;
    localparam int unsigned LOW_BITS  = $clog2(ENTRY_BYTES);

    if (PAGE_SHIFT < 2 || PAGE_SHIFT >= ADDR_W) begin : g_bad_shift
        $error("iopte_idx_calc: PAGE_SHIFT out of range");
    end

    logic [ADDR_W-1:0] in_window;
    logic [ADDR_W-1:0] scaled_idx;
    logic [ADDR_W-1:0] entry_off;
    logic [ADDR_W-1:0] table_base;

    always_comb begin
        in_window  = vaddr_i & ~window_i;
        scaled_idx = in_window >> IDX_SHIFT;
        entry_off  = {scaled_idx[ADDR_W-1:LOW_BITS], {LOW_BITS{1'b0}}};
        table_base = base_i << BASE_SCALE;
        pte_addr_o = table_base + entry_off;
    end

endmodule

// File: rtl/iopte_fetch_ctrl.sv
module iopte_fetch_ctrl
    import iopte_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] pte_addr_i,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output word_t             rsp_flags,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              rd_valid,
    input  word_t             rd_data
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        word_t             flags;
    } pending_t;

    fetch_state_e state_q, state_d;
    pending_t     pend_q, pend_d;

    always_comb begin
        state_d = state_q;
        pend_d  = pend_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    pend_d.addr = pte_addr_i;
                    state_d     = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (mem_ready) begin
                    state_d = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (rd_valid) begin
                    pend_d.flags = reverse_bytes(rd_data);
                    state_d      = ST_RESP;
                end
            end
            ST_RESP: begin
                if (rsp_ready) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign mem_valid = (state_q == ST_ISSUE);
    assign rsp_valid = (state_q == ST_RESP);
    assign mem_addr  = pend_q.addr;
    assign rsp_flags = pend_q.flags;

    p_addr_stable_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));

    p_rsp_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_flags)));

    p_single_out_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    p_rsp_after_data_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(rsp_valid) |-> $past(rd_valid));

    p_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
        !(mem_valid && rsp_valid) && !(req_ready && (mem_valid || rsp_valid)));

endmodule

// File: rtl/iopte_fetch.sv
module iopte_fetch
    import iopte_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned PAGE_SHIFT = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [31:0]       rsp_flags,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              rd_valid,
    input  logic [31:0]       rd_data
);

    logic [ADDR_W-1:0] base_w;
    logic [ADDR_W-1:0] window_w;
    logic [ADDR_W-1:0] pte_addr_w;

    iopte_cfg_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .base_o    (base_w),
        .window_o  (window_w)
    );

    iopte_idx_calc #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) u_idx (
        .base_i     (base_w),
        .window_i   (window_w),
        .vaddr_i    (req_vaddr),
        .pte_addr_o (pte_addr_w)
    );

    iopte_fetch_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .pte_addr_i (pte_addr_w),
        .rsp_valid  (rsp_valid),
        .rsp_ready  (rsp_ready),
        .rsp_flags  (rsp_flags),
        .mem_valid  (mem_valid),
        .mem_ready  (mem_ready),
        .mem_addr   (mem_addr),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );

    p_issue_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (mem_valid && mem_addr == $past(pte_addr_w)));

endmodule

// File: tb/test_iopte_fetch.sv
`timescale 1ns/1ps
module test_iopte_fetch;

    localparam int unsigned AW = 32;
    localparam int unsigned PS = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic          cfg_sel = 1'b0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_vaddr = '0;
    logic          rsp_valid;
    logic          rsp_ready = 1'b0;
    logic [31:0]   rsp_flags;
    logic          mem_valid;
    logic          mem_ready = 1'b0;
    logic [AW-1:0] mem_addr;
    logic          rd_valid = 1'b0;
    logic [31:0]   rd_data = '0;

    int total = 0;
    int bad   = 0;
    logic [AW-1:0] cur_base = '0;
    logic [AW-1:0] cur_win  = '0;

    always #2.5 clk = ~clk;

    iopte_fetch #(.ADDR_W(AW), .PAGE_SHIFT(PS)) i_iopte_fetch (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_flags(rsp_flags),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] model_addr(logic [AW-1:0] b, logic [AW-1:0] w, logic [AW-1:0] a);
        logic [AW-1:0] off;
        off = ((a & ~w) / (1 << (PS - 2)));
        off = off - (off % 4);
        return (b * 16) + off;
    endfunction

    function automatic logic [31:0] model_swap(logic [31:0] d);
        return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cfg_write(input logic sel, input logic [AW-1:0] val);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        tick();
        cfg_we = 1'b0;
        if (sel) cur_win = val; else cur_base = val;
    endtask

    // One lookup; optionally rewrites both registers while the address is stalled (R7)
    // and pulses rd_valid before the address handshake (R8).
    task automatic lookup(input logic [AW-1:0] va, input logic [31:0] word,
                          input int mlat, input int rlat, input bit disturb);
        logic [AW-1:0] exp_a;
        exp_a = model_addr(cur_base, cur_win, va);
        req_valid = 1'b1; req_vaddr = va;
        tick();
        req_valid = 1'b0;
        check("R2 mem_valid", 64'(mem_valid), 64'd1);
        check("R2 mem_addr", 64'(mem_addr), 64'(exp_a));
        check("R6 req_ready low", 64'(req_ready), 64'd0);
        check("R9 no rsp during read", 64'(rsp_valid), 64'd0);
        if (disturb) begin
            rd_valid = 1'b1; rd_data = 32'hDEAD_BEEF;
            cfg_write(1'b0, cur_base ^ 32'h0F0F_1234);
            rd_valid = 1'b0;
            cfg_write(1'b1, cur_win ^ 32'hFF00_0000);
            check("R8 stray rd_valid", 64'(rsp_valid), 64'd0);
            check("R7 addr after cfg", 64'(mem_addr), 64'(exp_a));
        end
        for (int i = 0; i < mlat; i++) begin
            tick();
            check("R4 held valid", 64'(mem_valid), 64'd1);
            check("R4 held addr", 64'(mem_addr), 64'(exp_a));
        end
        mem_ready = 1'b1;
        tick();
        mem_ready = 1'b0;
        check("R4 valid dropped", 64'(mem_valid), 64'd0);
        tick();
        rd_valid = 1'b1; rd_data = word;
        tick();
        rd_valid = 1'b0; rd_data = '0;
        check("R5 rsp_valid", 64'(rsp_valid), 64'd1);
        check("R5 flags", 64'(rsp_flags), 64'(model_swap(word)));
        for (int i = 0; i < rlat; i++) begin
            tick();
            check("R6 rsp held", 64'(rsp_valid), 64'd1);
            check("R6 flags held", 64'(rsp_flags), 64'(model_swap(word)));
            check("R6 busy", 64'(req_ready), 64'd0);
        end
        rsp_ready = 1'b1;
        tick();
        rsp_ready = 1'b0;
        check("R6 ready again", 64'(req_ready), 64'd1);
        check("R9 rsp cleared", 64'(rsp_valid), 64'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        logic [31:0] lfsr;
        lfsr = 32'hACE1_2468;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 req_ready", 64'(req_ready), 64'd1);
        check("R1 mem_valid", 64'(mem_valid), 64'd0);
        check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
        // registers read back through the address: zero base and window
        lookup(32'h0001_5000, 32'h1122_3344, 0, 0, 1'b0);
        check("R1 zero regs", 64'(mem_addr), 64'(32'h0000_0054));

        cfg_write(1'b0, 32'h0123_4560);
        cfg_write(1'b1, 32'hF000_0000);
        check("R3 regs", 64'(model_addr(cur_base, cur_win, 32'hF000_3000)), 64'(32'h1234_560C));
        lookup(32'hF000_3000, 32'hA1B2_C3D4, 2, 1, 1'b0);

        // stalled-address configuration change and stray rd_valid
        lookup(32'h0ABC_DFFF, 32'h0000_00FF, 3, 0, 1'b1);
        // next lookup sees the new registers
        lookup(32'h0ABC_DFFF, 32'hFF00_0000, 0, 2, 1'b0);

        // corners: sum overflow, all-ones window, all-ones address
        cfg_write(1'b0, 32'hFFFF_FFFF);
        cfg_write(1'b1, 32'h0000_0000);
        lookup(32'hFFFF_FFFF, 32'h8000_0001, 1, 0, 1'b0);
        cfg_write(1'b1, 32'hFFFF_FFFF);
        lookup(32'h1234_5678, 32'h0102_0304, 0, 0, 1'b0);
        check("R2 full window", 64'(mem_addr), 64'(32'hFFFF_FFF0));

        // sweep over base / window / address patterns
        for (int i = 0; i < 48; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            if (i % 4 == 0) cfg_write(1'b0, lfsr);
            if (i % 6 == 1) cfg_write(1'b1, {lfsr[15:0], 16'h0} & 32'hFFF0_0000);
            lookup({lfsr[7:0], lfsr[31:8]}, lfsr ^ 32'h5A5A_A5A5, i % 3, i % 2, (i % 8) == 5);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule